// File: doc/BRIEF.md
# Zone-Based Memory Access Map

The block keeps a compact history of recent memory traffic. Physical memory is split into zones of 16 KB, each made of 256 lines of 64 bytes. One table entry stands for one zone. It holds the zone tag, a one-bit state per line (untouched or touched) and a pair of statistics counters. Every request carries a byte address. The block finds the zone in the table, or allocates an entry for it. It then tells downstream logic whether the line being touched was already touched since the zone entered the table. A touched line is a data reuse and an untouched one is a first touch.

With each answer the block also returns the entry's access count and reuse count. Their ratio shows how often neighbouring lines of the same zone are reused, so a replacement or insertion decision elsewhere can weigh spatial locality. The table is set-associative: 16 sets of 12 ways by default. The ways of a set are replaced in least-recently-used order.

Top module: `zmap_table`

## Requirements
- R1: After reset, `resp_valid` is low and every entry is invalid, so the first request to any zone reports a map miss.
- R2: `resp_valid` is high in exactly the cycle after each cycle in which `req_valid` is high, and low otherwise. Back-to-back requests each see the updates made by the ones before them.
- R3: An access to a line in the untouched state reports `resp_reuse` = 0 and moves the line to the touched state.
- R4: An access to a line already in the touched state reports `resp_reuse` = 1. A reuse is only ever reported together with a map hit.
- R5: The address splits as follows: bits [5:0] are the byte offset, [13:6] the line index, [31:14] the zone number, [17:14] the set index and [31:18] the tag. A map hit is reported when a valid way of the selected set holds the request's tag, and at most one way matches.
- R6: The reported counts are the entry's values before this access. On a map miss both counts read 0 and the reuse flag reads 0.
- R7: Each access adds 1 to the entry's access count, and each reuse also adds 1 to its reuse count. The reuse count never exceeds the access count.
- R8: Both counts are 8 bits wide. If the access count is 255, or if the reuse count is 255 and the access is a reuse, both counts are first halved (rounded down) and then incremented as in R7.
- R9: On a map miss the lowest-numbered invalid way of the set is filled. If every way is valid, the least-recently-used way is filled instead. Every lookup makes its way the most recently used. A newly filled entry starts with all lines untouched and both counts at 0, and the current access is then recorded as a first touch.
- R10: The byte offset bits [5:0] have no effect: two addresses in the same 64-byte line are the same line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | 32 | Physical byte address of the access |
| resp_valid | output | 1 | Response valid, one cycle after the request |
| resp_map_hit | output | 1 | Zone found in the table |
| resp_reuse | output | 1 | Line was already touched (data reuse) |
| resp_access_cnt | output | 8 | Entry access count before this access |
| resp_reuse_cnt | output | 8 | Entry reuse count before this access |

## Verification
The assertions check the per-cycle rules on every cycle. These are the one-cycle response timing, the zeroed report on a miss, a reuse only on a hit, the reuse count never above the access count, at most one matching way, and the presence of a replaceable way once a set is full. Other behaviour needs the bench's scenarios against its reference model: the exact count values, the halving at saturation, the order in which LRU evicts ways, the loss of line history after an eviction, and the fact that offset bits are ignored. To reach them the bench sends directed sequences and seeded random traffic confined to a few sets, so that eviction happens often.

// File: rtl/zmap_pkg.sv
package zmap_pkg;
   typedef enum logic {
      LINE_UNTOUCHED = 1'b0,
      LINE_TOUCHED   = 1'b1
   } line_state_e;
endpackage

// File: rtl/zmap_cnt_update.sv
module zmap_cnt_update #(
   parameter int CNT_W = 8
) (
   input  logic [CNT_W-1:0] acc_i,
   input  logic [CNT_W-1:0] reu_i,
   input  logic             is_reuse_i,
   output logic [CNT_W-1:0] acc_o,
   output logic [CNT_W-1:0] reu_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             sat;
   logic [CNT_W-1:0] acc_base;
   logic [CNT_W-1:0] reu_base;

   always_comb begin
      sat      = (acc_i == CNT_MAX) || (is_reuse_i && (reu_i == CNT_MAX));
      acc_base = sat ? (acc_i >> 1) : acc_i;
      reu_base = sat ? (reu_i >> 1) : reu_i;
      acc_o    = acc_base + CNT_W'(1);
      reu_o    = reu_base + CNT_W'(is_reuse_i);
   end
endmodule

// File: rtl/zmap_tag_match.sv
module zmap_tag_match #(
   parameter int WAYS  = 12,
   parameter int TAG_W = 14,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]  valid_i,
   input  logic [TAG_W-1:0] tags_i [WAYS],
   input  logic [TAG_W-1:0] tag_i,
   output logic [WAYS-1:0]  match_o,
   output logic             hit_o,
   output logic [WAY_W-1:0] hit_way_o
);
   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match_o[w] = valid_i[w] && (tags_i[w] == tag_i);
   end

   assign hit_o = |match_o;

   always_comb begin
      hit_way_o = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (match_o[w]) hit_way_o = WAY_W'(w);
      end
   end
endmodule

// File: rtl/zmap_lru.sv
module zmap_lru #(
   parameter int SETS = 16,
   parameter int WAYS = 12,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS),
   localparam int AGE_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch_i,
   input  logic [SET_W-1:0] set_i,
   input  logic [WAY_W-1:0] way_i,
   input  logic [WAYS-1:0]  valid_i,
   output logic [WAY_W-1:0] victim_o
);
   localparam logic [AGE_W-1:0] AGE_OLDEST = AGE_W'(WAYS - 1);

   logic [AGE_W-1:0] age_q [SETS][WAYS];
   logic             any_invalid;
   logic             oldest_found;
   logic [WAY_W-1:0] inv_way;
   logic [WAY_W-1:0] old_way;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
               age_q[s][w] <= AGE_W'(w);
      end else if (touch_i) begin
         for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == way_i)
               age_q[set_i][w] <= '0;
            else if (age_q[set_i][w] < age_q[set_i][way_i])
               age_q[set_i][w] <= age_q[set_i][w] + AGE_W'(1);
         end
      end
   end

   always_comb begin
      any_invalid  = 1'b0;
      oldest_found = 1'b0;
      inv_way      = '0;
      old_way      = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!valid_i[w]) begin
            any_invalid = 1'b1;
            inv_way     = WAY_W'(w);
         end
         if (age_q[set_i][w] == AGE_OLDEST) begin
            oldest_found = 1'b1;
            old_way      = WAY_W'(w);
         end
      end
      victim_o = any_invalid ? inv_way : old_way;
   end

   p_victim_found_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (touch_i && (&valid_i)) |-> oldest_found);
endmodule

// File: rtl/zmap_table.sv
module zmap_table #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int ZONE_LINES = 256,
   parameter int SETS       = 16,
   parameter int WAYS       = 12,
   parameter int CNT_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              resp_valid,
   output logic              resp_map_hit,
   output logic              resp_reuse,
   output logic [CNT_W-1:0]  resp_access_cnt,
   output logic [CNT_W-1:0]  resp_reuse_cnt
);
   import zmap_pkg::*;

   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int LINE_W = $clog2(ZONE_LINES);
   localparam int SET_W  = $clog2(SETS);
   localparam int WAY_W  = $clog2(WAYS);
   localparam int ZONE_LSB = OFF_W + LINE_W;
   localparam int TAG_LSB  = ZONE_LSB + SET_W;
   localparam int TAG_W    = ADDR_W - TAG_LSB;

   if ((1 << OFF_W) != LINE_BYTES || (1 << LINE_W) != ZONE_LINES
       || (1 << SET_W) != SETS) begin : g_bad_pow2
      $error("zmap_table: line size, zone lines and sets must be powers of two");
   end
   if (WAYS < 2 || TAG_W < 1 || CNT_W < 2) begin : g_bad_shape
      $error("zmap_table: need at least 2 ways, 1 tag bit and 2 counter bits");
   end

   logic                  valid_q [SETS][WAYS];
   logic [TAG_W-1:0]      tag_q   [SETS][WAYS];
   logic [ZONE_LINES-1:0] map_q   [SETS][WAYS];
   logic [CNT_W-1:0]      acc_q   [SETS][WAYS];
   logic [CNT_W-1:0]      reu_q   [SETS][WAYS];

   logic [SET_W-1:0]      set_idx;
   logic [TAG_W-1:0]      req_tag;
   logic [LINE_W-1:0]     line_idx;
   logic [WAYS-1:0]       set_valid;
   logic [TAG_W-1:0]      set_tags [WAYS];
   logic [WAYS-1:0]       match_vec;
   logic                  hit;
   logic [WAY_W-1:0]      hit_way;
   logic [WAY_W-1:0]      victim_way;
   logic [WAY_W-1:0]      sel_way;
   logic [ZONE_LINES-1:0] cur_map;
   logic [ZONE_LINES-1:0] new_map;
   line_state_e           old_state;
   logic                  is_reuse;
   logic [CNT_W-1:0]      old_acc;
   logic [CNT_W-1:0]      old_reu;
   logic [CNT_W-1:0]      new_acc;
   logic [CNT_W-1:0]      new_reu;

   assign set_idx  = req_addr[ZONE_LSB +: SET_W];
   assign req_tag  = req_addr[TAG_LSB +: TAG_W];
   assign line_idx = req_addr[OFF_W +: LINE_W];

   for (genvar w = 0; w < WAYS; w++) begin : g_rd
      assign set_valid[w] = valid_q[set_idx][w];
      assign set_tags[w]  = tag_q[set_idx][w];
   end

   zmap_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) match_i (
      .valid_i   (set_valid),
      .tags_i    (set_tags),
      .tag_i     (req_tag),
      .match_o   (match_vec),
      .hit_o     (hit),
      .hit_way_o (hit_way)
   );

   zmap_lru #(.SETS(SETS), .WAYS(WAYS)) lru_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .touch_i  (req_valid),
      .set_i    (set_idx),
      .way_i    (sel_way),
      .valid_i  (set_valid),
      .victim_o (victim_way)
   );

   always_comb begin
      sel_way   = hit ? hit_way : victim_way;
      cur_map   = hit ? map_q[set_idx][hit_way] : '0;
      old_state = line_state_e'(cur_map[line_idx]);
      is_reuse  = (old_state == LINE_TOUCHED);
      old_acc   = hit ? acc_q[set_idx][hit_way] : '0;
      old_reu   = hit ? reu_q[set_idx][hit_way] : '0;
      new_map   = cur_map;
      new_map[line_idx] = LINE_TOUCHED;
   end

   zmap_cnt_update #(.CNT_W(CNT_W)) cnt_i (
      .acc_i      (old_acc),
      .reu_i      (old_reu),
      .is_reuse_i (is_reuse),
      .acc_o      (new_acc),
      .reu_o      (new_reu)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
               valid_q[s][w] <= 1'b0;
      end else if (req_valid) begin
         valid_q[set_idx][sel_way] <= 1'b1;
         tag_q[set_idx][sel_way]   <= req_tag;
         map_q[set_idx][sel_way]   <= new_map;
         acc_q[set_idx][sel_way]   <= new_acc;
         reu_q[set_idx][sel_way]   <= new_reu;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resp_valid      <= 1'b0;
         resp_map_hit    <= 1'b0;
         resp_reuse      <= 1'b0;
         resp_access_cnt <= '0;
         resp_reuse_cnt  <= '0;
      end else begin
         resp_valid <= req_valid;
         if (req_valid) begin
            resp_map_hit    <= hit;
            resp_reuse      <= is_reuse;
            resp_access_cnt <= old_acc;
            resp_reuse_cnt  <= old_reu;
         end
      end
   end

   p_resp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> resp_valid);
   p_no_spurious_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !resp_valid);
   p_single_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> $onehot0(match_vec));
   p_miss_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !resp_map_hit) |->
         (!resp_reuse && resp_access_cnt == '0 && resp_reuse_cnt == '0));
   p_reuse_on_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_reuse) |-> resp_map_hit);
   p_reuse_le_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> (resp_reuse_cnt <= resp_access_cnt));
endmodule

// File: tb/zmap_table_tb_top.sv
module zmap_table_tb_top;
   localparam int SETS = 16;
   localparam int WAYS = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        resp_valid;
   logic        resp_map_hit;
   logic        resp_reuse;
   logic [7:0]  resp_access_cnt;
   logic [7:0]  resp_reuse_cnt;

   int tests_run = 0;
   int tests_failed = 0;

   always #5 clk = ~clk;

   zmap_table dut_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .req_valid       (req_valid),
      .req_addr        (req_addr),
      .resp_valid      (resp_valid),
      .resp_map_hit    (resp_map_hit),
      .resp_reuse      (resp_reuse),
      .resp_access_cnt (resp_access_cnt),
      .resp_reuse_cnt  (resp_reuse_cnt)
   );

   // reference model
   bit         m_valid [SETS][WAYS];
   bit [13:0]  m_tag   [SETS][WAYS];
   bit [255:0] m_map   [SETS][WAYS];
   int         m_acc   [SETS][WAYS];
   int         m_reu   [SETS][WAYS];
   longint     m_used  [SETS][WAYS];
   longint     m_clock = 0;

   bit e_hit, e_reuse;
   int e_acc, e_reu;

   function automatic bit [31:0] mk_addr(int tag, int set, int line, int off);
      return {14'(tag), 4'(set), 8'(line), 6'(off)};
   endfunction

   task automatic model_access(bit [31:0] a);
      int s = int'(a[17:14]);
      bit [13:0] t = a[31:18];
      int l = int'(a[13:6]);
      int w = -1;
      bit sat;
      for (int i = 0; i < WAYS; i++)
         if (m_valid[s][i] && m_tag[s][i] == t) w = i;
      e_hit = (w >= 0);
      if (!e_hit) begin
         for (int i = WAYS - 1; i >= 0; i--)
            if (!m_valid[s][i]) w = i;
         if (w < 0) begin
            w = 0;
            for (int i = 1; i < WAYS; i++)
               if (m_used[s][i] < m_used[s][w]) w = i;
         end
         m_valid[s][w] = 1'b1;
         m_tag[s][w]   = t;
         m_map[s][w]   = '0;
         m_acc[s][w]   = 0;
         m_reu[s][w]   = 0;
      end
      e_reuse = m_map[s][w][l];
      e_acc   = m_acc[s][w];
      e_reu   = m_reu[s][w];
      sat = (e_acc == 255) || (e_reuse && e_reu == 255);
      m_acc[s][w] = (sat ? e_acc / 2 : e_acc) + 1;
      m_reu[s][w] = (sat ? e_reu / 2 : e_reu) + (e_reuse ? 1 : 0);
      m_map[s][w][l] = 1'b1;
      m_clock++;
      m_used[s][w] = m_clock;
   endtask

   task automatic check(string tag, string what, int act, int exp);
      tests_run++;
      if (act != exp) begin
         tests_failed++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // one request; response checked at the next falling edge
   task automatic access(bit [31:0] a, string tag);
      model_access(a);
      req_valid = 1'b1;
      req_addr  = a;
      @(negedge clk);
      check(tag, "resp_valid", int'(resp_valid), 1);
      check(tag, "map_hit", int'(resp_map_hit), int'(e_hit));
      check(tag, "reuse", int'(resp_reuse), int'(e_reuse));
      check(tag, "access_cnt", int'(resp_access_cnt), e_acc);
      check(tag, "reuse_cnt", int'(resp_reuse_cnt), e_reu);
   endtask

   task automatic idle();
      req_valid = 1'b0;
      @(negedge clk);
      check("R2", "resp_valid idle", int'(resp_valid), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
   end

   initial begin
      int seed;
      seed = 32'h5A17;
      void'($urandom(seed));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      check("R1", "resp_valid after reset", int'(resp_valid), 0);

      // R1/R6 first access misses; R3/R4/R10 line states; R7 counts
      access(mk_addr(3, 2, 5, 0), "R1");
      access(mk_addr(3, 2, 5, 63), "R10");
      access(mk_addr(3, 2, 6, 8), "R3");
      access(mk_addr(3, 2, 6, 0), "R4");
      access(mk_addr(3, 2, 5, 1), "R7");
      idle();
      access(mk_addr(3, 3, 5, 0), "R5");
      access(mk_addr(4, 2, 5, 0), "R5");
      idle();

      // R9 fill a set, then overflow it, then revisit the evicted zone
      for (int t = 0; t < WAYS; t++) access(mk_addr(100 + t, 7, 1, 0), "R9");
      access(mk_addr(100, 7, 1, 0), "R9");
      access(mk_addr(200, 7, 1, 0), "R9");
      access(mk_addr(101, 7, 1, 0), "R9");
      access(mk_addr(101, 7, 2, 0), "R9");
      idle();

      // R8 saturation and halving
      for (int i = 0; i < 300; i++) access(mk_addr(9, 4, 0, i % 64), "R8");
      for (int i = 0; i < 300; i++) access(mk_addr(10, 4, i % 256, 0), "R8");
      idle();

      // random traffic confined to a few sets
      for (int i = 0; i < 4000; i++) begin
         int s = int'($urandom_range(0, 2));
         int t = int'($urandom_range(0, 15));
         int l = int'($urandom_range(0, 15));
         int o = int'($urandom_range(0, 63));
         access(mk_addr(t, s, l, o), "R7");
         if ($urandom_range(0, 9) == 0) idle();
      end
      idle();

      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
   end
endmodule